// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a hardware master for the two-wire serial management bus that reaches the registers of Ethernet PHYs. A client presents one request on a flat command port: read or write, short (Clause 22) or extended (Clause 45) framing, a 5-bit PHY address, a 21-bit register address and 16 bits of write data. The block produces the management clock (MDC) and drives the shared data line through separate output, output-enable and input signals. The pad tristate buffer sits outside the block.

For each request the master sends a 32-bit all-ones preamble, the start and opcode bits, and both address fields. For a write it then sends the turnaround pattern and the data. For a read it releases the line and samples the turnaround bit and the data. An extended request runs as two frames, one after the other: an address frame that carries the low 16 address bits, then the read or write frame. A PHY that fails to pull the turnaround bit low makes the master clock 32 flush bits and return all ones with an error flag. A per-PHY ignore mask turns that check off for PHYs known to misbehave.

Timing is set in system clock cycles. `HALF_CYC` sets the MDC low phase and the high phase of driven bits. `RD_HIGH_CYC` sets the high phase of bits the PHY drives, and read data is sampled at the end of that phase. The defaults (25 and 35 at 100 MHz) give 250 ns and 350 ns.

Top module: `mdio_master`

## Requirements
- R1: After reset and between transactions `busy`, `done`, `mdc` and `mdio_oe` are all low.
- R2: Each frame opens with 32 driven one bits. Then come the start bits, 0 then 1 for Clause 22 or 0 then 0 for Clause 45, then two opcode bits, the 5-bit PHY address and the 5-bit register or device address. All fields go out MSB first, and each bit is launched at a rising MDC edge.
- R3: The opcode bits are: Clause 22 read = 1,0 and write = 0,1. Clause 45 address = 0,0, read = 1,1 and write = 0,1.
- R4: A Clause 45 request (`cmd_c45`=1) sends two frames. First comes an address frame with device address `cmd_addr[20:16]` and data field `cmd_addr[15:0]`. Then comes the read or write frame with the same PHY and device address.
- R5: Write frames and address frames drive the turnaround bits 1 then 0 and the 16 data bits MSB first. The master then releases the line for one trailing bit, so a frame is 64 driven bits plus 1 released bit.
- R6: Read frames release the line after the register address: 1 turnaround bit, then 16 data bits MSB first, then 1 trailing bit, which makes 46 driven and 18 released bits. `rdata` returns the sampled data with `err`=0.
- R7: If the sampled turnaround bit is 1 and `ta_ignore_mask[phy]` is 0, the master clocks 32 more released bits and then ends with `rdata`=16'hFFFF and `err`=1.
- R8: If `ta_ignore_mask[phy]` is 1, a turnaround bit of 1 is ignored and the read completes normally.
- R9: MDC is high for `HALF_CYC` cycles on driven bits and for `RD_HIGH_CYC` cycles on released bits. The line input is sampled in the last cycle of the high phase. `mdio_o` and `mdio_oe` hold steady while MDC is high.
- R10: `busy` rises the cycle after an accepted `cmd_valid` and falls in the same cycle as a single-cycle `done`. A `cmd_valid` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request strobe, taken while idle |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_c45 | input | 1 | 1 = Clause 45 two-frame access |
| cmd_phy | input | 5 | PHY address |
| cmd_addr | input | 21 | Clause 22: [4:0] register; Clause 45: [20:16] device, [15:0] register |
| cmd_wdata | input | 16 | Write data |
| ta_ignore_mask | input | 32 | Per-PHY turnaround check disable |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Turnaround failure on the last request |
| rdata | output | 16 | Read data of the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Results are not due a fixed number of cycles after the command. The bench therefore works bit by bit. On the falling system edge after each MDC rise it logs `mdio_oe` and `mdio_o`, and it measures each high phase against `HALF_CYC` or `RD_HIGH_CYC`. The PHY response is placed on `mdio_i` at bit index N, and the master samples it at the end of that bit's high phase. `done`, `rdata` and `err` are read on the falling edge of the cycle in which `done` is high. Whole frames are then compared bit by bit against the frame expected from the request. The bit count is compared as well: 65 for a write or address frame, 64 for a good read, 79 for a failed read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;   // driven bits of a write/address frame
  localparam int HDR_BITS   = 46;   // preamble + start + op + two addresses
  localparam int DATA_BITS  = 16;
  localparam int FLUSH_BITS = 32;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SEND,
    SQ_TURN,
    SQ_RECV,
    SQ_FLUSH,
    SQ_TRAIL
  } seq_state_e;

  localparam logic [1:0] OP22_RD = 2'b10;
  localparam logic [1:0] OP22_WR = 2'b01;
  localparam logic [1:0] OP45_AD = 2'b00;
  localparam logic [1:0] OP45_RD = 2'b11;
  localparam logic [1:0] OP45_WR = 2'b01;

  // Bit 63 leaves first.
  function automatic logic [FRAME_BITS-1:0] pack_frame(
    input logic        ext,
    input logic [1:0]  op,
    input logic [4:0]  phy,
    input logic [4:0]  regad,
    input logic [15:0] data
  );
    return {32'hFFFF_FFFF, 1'b0, ~ext, op, phy, regad, 2'b10, data};
  endfunction

endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mdio_bit_clk.sv
module mdio_bit_clk #(
  parameter int HALF_CYC    = 25,
  parameter int RD_HIGH_CYC = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic rd,
  input  logic sin,
  output logic mdc,
  output logic run,
  output logic bit_end,
  output logic bit_val
);
  localparam int MAXC = (HALF_CYC > RD_HIGH_CYC) ? HALF_CYC : RD_HIGH_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          run_q, run_d, hi_q, hi_d, rd_q, rd_d;
  logic          end_q, end_d, val_q, val_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    hi_d  = hi_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    end_d = 1'b0;
    val_d = val_q;
    if (!run_q) begin
      if (go) begin
        run_d = 1'b1;
        hi_d  = 1'b0;
        rd_d  = rd;
        cnt_d = CW'(HALF_CYC - 1);
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else if (!hi_q) begin
      hi_d  = 1'b1;
      cnt_d = rd_q ? CW'(RD_HIGH_CYC - 1) : CW'(HALF_CYC - 1);
    end else begin
      run_d = 1'b0;
      hi_d  = 1'b0;
      end_d = 1'b1;
      val_d = sin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      hi_q  <= 1'b0;
      rd_q  <= 1'b0;
      cnt_q <= '0;
      end_q <= 1'b0;
      val_q <= 1'b0;
    end else begin
      run_q <= run_d;
      hi_q  <= hi_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      end_q <= end_d;
      val_q <= val_d;
    end
  end

  assign mdc     = hi_q;
  assign run     = run_q;
  assign bit_end = end_q;
  assign bit_val = val_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_read,
  input  logic        cmd_c45,
  input  logic [4:0]  cmd_phy,
  input  logic [20:0] cmd_addr,
  input  logic [15:0] cmd_wdata,
  input  logic [31:0] ta_ignore_mask,
  input  logic        eng_run,
  input  logic        bit_end,
  input  logic        bit_val,
  output logic        go,
  output logic        rd_bit,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata
);
  localparam logic [5:0] LAST_WR = 6'(FRAME_BITS - 1);
  localparam logic [5:0] LAST_RD = 6'(HDR_BITS - 1);
  localparam logic [5:0] LAST_DT = 6'(DATA_BITS - 1);
  localparam logic [5:0] LAST_FL = 6'(FLUSH_BITS - 1);

  seq_state_e            st_q, st_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [5:0]            cnt_q, cnt_d;
  logic                  rd_q, rd_d, wl_q, wl_d, pend_q, pend_d;
  logic [4:0]            phy_q, phy_d;
  logic [20:0]           addr_q, addr_d;
  logic [15:0]           wdat_q, wdat_d, shin_q, shin_d, rdata_q, rdata_d;
  logic                  done_q, done_d, err_q, err_d;

  always_comb begin
    st_d    = st_q;
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    wl_d    = wl_q;
    pend_d  = pend_q;
    phy_d   = phy_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    shin_d  = shin_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    err_d   = err_q;
    case (st_q)
      SQ_IDLE: if (cmd_valid) begin
        rd_d   = cmd_read;
        phy_d  = cmd_phy;
        addr_d = cmd_addr;
        wdat_d = cmd_wdata;
        st_d   = SQ_SEND;
        if (cmd_c45) begin
          sr_d   = pack_frame(1'b1, OP45_AD, cmd_phy, cmd_addr[20:16], cmd_addr[15:0]);
          wl_d   = 1'b1;
          pend_d = 1'b1;
          cnt_d  = LAST_WR;
        end else begin
          sr_d   = pack_frame(1'b0, cmd_read ? OP22_RD : OP22_WR, cmd_phy,
                              cmd_addr[4:0], cmd_wdata);
          wl_d   = ~cmd_read;
          pend_d = 1'b0;
          cnt_d  = cmd_read ? LAST_RD : LAST_WR;
        end
      end
      SQ_SEND: if (bit_end) begin
        sr_d = {sr_q[FRAME_BITS-2:0], 1'b1};
        if (cnt_q == '0) st_d = wl_q ? SQ_TRAIL : SQ_TURN;
        else             cnt_d = cnt_q - 1'b1;
      end
      SQ_TURN: if (bit_end) begin
        if (bit_val && !ta_ignore_mask[phy_q]) begin
          st_d  = SQ_FLUSH;
          cnt_d = LAST_FL;
        end else begin
          st_d  = SQ_RECV;
          cnt_d = LAST_DT;
        end
      end
      SQ_RECV: if (bit_end) begin
        shin_d = {shin_q[14:0], bit_val};
        if (cnt_q == '0) st_d = SQ_TRAIL;
        else             cnt_d = cnt_q - 1'b1;
      end
      SQ_FLUSH: if (bit_end) begin
        if (cnt_q == '0) begin
          st_d    = SQ_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
          rdata_d = 16'hFFFF;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_TRAIL: if (bit_end) begin
        if (pend_q) begin
          pend_d = 1'b0;
          sr_d   = pack_frame(1'b1, rd_q ? OP45_RD : OP45_WR, phy_q,
                              addr_q[20:16], wdat_q);
          wl_d   = ~rd_q;
          cnt_d  = rd_q ? LAST_RD : LAST_WR;
          st_d   = SQ_SEND;
        end else begin
          st_d   = SQ_IDLE;
          done_d = 1'b1;
          err_d  = 1'b0;
          if (rd_q) rdata_d = shin_q;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      sr_q    <= '1;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      wl_q    <= 1'b0;
      pend_q  <= 1'b0;
      phy_q   <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      shin_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      wl_q    <= wl_d;
      pend_q  <= pend_d;
      phy_q   <= phy_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      shin_q  <= shin_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign go      = (st_q != SQ_IDLE) && !eng_run && !bit_end;
  assign rd_bit  = (st_q != SQ_SEND);
  assign mdio_oe = (st_q == SQ_SEND);
  assign mdio_o  = mdio_oe & sr_q[FRAME_BITS-1];
  assign busy    = (st_q != SQ_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_CYC    = 25,
  parameter int RD_HIGH_CYC = 35
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_read,
  input  logic        cmd_c45,
  input  logic [4:0]  cmd_phy,
  input  logic [20:0] cmd_addr,
  input  logic [15:0] cmd_wdata,
  input  logic [31:0] ta_ignore_mask,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic rst_i_n, go, rd_bit, eng_run, bit_end, bit_val;

  mdio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  mdio_bit_clk #(
    .HALF_CYC    (HALF_CYC),
    .RD_HIGH_CYC (RD_HIGH_CYC)
  ) u_bit (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .go      (go),
    .rd      (rd_bit),
    .sin     (mdio_i),
    .mdc     (mdc),
    .run     (eng_run),
    .bit_end (bit_end),
    .bit_val (bit_val)
  );

  mdio_frame_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_i_n),
    .cmd_valid      (cmd_valid),
    .cmd_read       (cmd_read),
    .cmd_c45        (cmd_c45),
    .cmd_phy        (cmd_phy),
    .cmd_addr       (cmd_addr),
    .cmd_wdata      (cmd_wdata),
    .ta_ignore_mask (ta_ignore_mask),
    .eng_run        (eng_run),
    .bit_end        (bit_end),
    .bit_val        (bit_val),
    .go             (go),
    .rd_bit         (rd_bit),
    .mdio_o         (mdio_o),
    .mdio_oe        (mdio_oe),
    .busy           (busy),
    .done           (done),
    .err            (err),
    .rdata          (rdata)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [15:0] rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R9
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R7
  fail_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rdata == 16'hFFFF));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .rdata     (rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int HALF = 4;
  localparam int RDH  = 6;

  logic        clk, rst_n, cmd_valid, cmd_read, cmd_c45;
  logic [4:0]  cmd_phy;
  logic [20:0] cmd_addr;
  logic [15:0] cmd_wdata, rdata;
  logic [31:0] ta_ignore_mask;
  logic        busy, done, err, mdc, mdio_o, mdio_oe, mdio_i, phy_val;

  int n_tests, n_fail;
  int nbits, hcnt;
  logic       prev_mdc;
  logic [1:0] blog [512];
  int         hlen [512];
  logic       resp [512];
  logic [15:0] got_rd;
  logic        got_err, got_busy, got_ok;

  mdio_master #(.HALF_CYC(HALF), .RD_HIGH_CYC(RDH)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_c45(cmd_c45), .cmd_phy(cmd_phy), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .ta_ignore_mask(ta_ignore_mask), .busy(busy),
    .done(done), .err(err), .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = mdio_oe ? mdio_o : phy_val;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Bit monitor and PHY responder, sampled on the falling system edge.
  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      if (nbits < 512) begin
        blog[nbits] = {mdio_oe, mdio_o};
        phy_val     = resp[nbits];
      end
      nbits = nbits + 1;
      hcnt  = 1;
    end else if (mdc) begin
      hcnt = hcnt + 1;
    end
    if (!mdc && prev_mdc && nbits > 0 && nbits <= 512) hlen[nbits-1] = hcnt;
    prev_mdc = mdc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    nbits = 0;
    for (int i = 0; i < 512; i++) resp[i] = 1'b1;
    phy_val = 1'b1;
  endtask

  task automatic issue(input bit rd, input bit ext, input logic [4:0] phy,
                       input logic [20:0] ad, input logic [15:0] wd);
    @(negedge clk);
    cmd_read = rd; cmd_c45 = ext; cmd_phy = phy; cmd_addr = ad; cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    got_ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin
        got_ok = 1'b1; got_rd = rdata; got_err = err; got_busy = busy;
        break;
      end
    end
    chk(got_ok, "R10 done seen", int'(got_ok), 1);
    chk(!got_busy, "R10 busy low with done", int'(got_busy), 0);
  endtask

  // Compares one frame starting at log index base.
  task automatic check_frame(input int base, input bit ext, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] dat, input bit wl, input string req);
    logic [63:0] exp;
    int nd, nr, bad, first;
    exp = {32'hFFFF_FFFF, 1'b0, !ext, op, phy, ra, 2'b10, dat};
    nd = wl ? 64 : 46;
    nr = wl ? 1 : 18;
    bad = 0; first = -1;
    for (int i = 0; i < nd; i++)
      if (blog[base+i] !== {1'b1, exp[63-i]} || hlen[base+i] != HALF) begin
        bad++; if (first < 0) first = i;
      end
    for (int j = nd; j < nd + nr; j++)
      if (blog[base+j][1] !== 1'b0 || hlen[base+j] != RDH) begin
        bad++; if (first < 0) first = j;
      end
    chk(bad == 0, req, first, -1);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mdc && !mdio_oe, "R1 reset idle",
        {busy, done, mdc, mdio_oe}, 0);
  endtask

  task automatic t_c22_write();
    clear_log();
    issue(1'b0, 1'b0, 5'h05, 21'h0001A, 16'hA5C3);
    wait_done();
    chk(nbits == 65, "R5 write bit count", nbits, 65);
    check_frame(0, 1'b0, 2'b01, 5'h05, 5'h1A, 16'hA5C3, 1'b1, "R2 R3 R5 R9 c22 write frame");
    chk(!got_err, "R5 write err", int'(got_err), 0);
    chk(!mdc && !mdio_oe, "R1 idle after write", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_c22_read();
    clear_log();
    resp[46] = 1'b0;
    for (int i = 0; i < 16; i++) resp[47+i] = 16'h1234 >> (15 - i);
    issue(1'b1, 1'b0, 5'h11, 21'h00003, 16'h0);
    wait_done();
    chk(nbits == 64, "R6 read bit count", nbits, 64);
    check_frame(0, 1'b0, 2'b10, 5'h11, 5'h03, 16'h0, 1'b0, "R2 R3 R6 R9 c22 read frame");
    chk(got_rd == 16'h1234 && !got_err, "R6 read data", got_rd, 16'h1234);
  endtask

  task automatic t_ta_fail();
    clear_log();
    for (int i = 0; i < 16; i++) resp[47+i] = 1'b0;
    issue(1'b1, 1'b0, 5'h02, 21'h00001, 16'h0);
    wait_done();
    chk(nbits == 79, "R7 flush bit count", nbits, 79);
    chk(got_rd == 16'hFFFF, "R7 all ones", got_rd, 16'hFFFF);
    chk(got_err, "R7 err flag", int'(got_err), 1);
  endtask

  task automatic t_ta_masked();
    clear_log();
    ta_ignore_mask = 32'h0000_0004;
    for (int i = 0; i < 16; i++) resp[47+i] = 16'h5A0F >> (15 - i);
    issue(1'b1, 1'b0, 5'h02, 21'h00001, 16'h0);
    wait_done();
    ta_ignore_mask = 32'h0;
    chk(nbits == 64, "R8 masked bit count", nbits, 64);
    chk(got_rd == 16'h5A0F && !got_err, "R8 masked read data", got_rd, 16'h5A0F);
  endtask

  task automatic t_c45_write();
    clear_log();
    issue(1'b0, 1'b1, 5'h03, 21'h1FBEEF, 16'h0F0F);
    wait_done();
    chk(nbits == 130, "R4 c45 write bit count", nbits, 130);
    check_frame(0, 1'b1, 2'b00, 5'h03, 5'h1F, 16'hBEEF, 1'b1, "R4 R3 c45 address frame");
    check_frame(65, 1'b1, 2'b01, 5'h03, 5'h1F, 16'h0F0F, 1'b1, "R4 R5 c45 write frame");
  endtask

  task automatic t_c45_read();
    clear_log();
    resp[111] = 1'b0;
    for (int i = 0; i < 16; i++) resp[112+i] = 16'hC0DE >> (15 - i);
    issue(1'b1, 1'b1, 5'h1C, 21'h0A0102, 16'h0);
    wait_done();
    chk(nbits == 129, "R4 c45 read bit count", nbits, 129);
    check_frame(0, 1'b1, 2'b00, 5'h1C, 5'h0A, 16'h0102, 1'b1, "R4 c45 read address frame");
    check_frame(65, 1'b1, 2'b11, 5'h1C, 5'h0A, 16'h0, 1'b0, "R4 R6 c45 read frame");
    chk(got_rd == 16'hC0DE && !got_err, "R4 c45 read data", got_rd, 16'hC0DE);
  endtask

  task automatic t_busy_ignore();
    clear_log();
    issue(1'b0, 1'b0, 5'h01, 21'h00002, 16'h0003);
    chk(busy, "R10 busy after accept", int'(busy), 1);
    repeat (20) @(negedge clk);
    cmd_read = 1'b1; cmd_c45 = 1'b1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    repeat (300) @(negedge clk);
    chk(nbits == 65 && !busy, "R10 command while busy ignored", nbits, 65);
    check_frame(0, 1'b0, 2'b01, 5'h01, 5'h02, 16'h0003, 1'b1, "R10 first command intact");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0; nbits = 0; hcnt = 0; prev_mdc = 1'b0; phy_val = 1'b1;
    cmd_valid = 1'b0; cmd_read = 1'b0; cmd_c45 = 1'b0; cmd_phy = '0;
    cmd_addr = '0; cmd_wdata = '0; ta_ignore_mask = 32'h0;
    for (int i = 0; i < 512; i++) begin resp[i] = 1'b1; hlen[i] = 0; blog[i] = 2'b00; end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_c22_write();
    t_c22_read();
    t_ta_fail();
    t_ta_masked();
    t_c45_write();
    t_c45_read();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule